// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block keeps a 64-bit signed accumulator and updates it in one clock per operation. Each operation takes two 32-bit signed operands. It can add their full 64-bit product to the accumulator or subtract it. A third operation hands back a 32-bit window of the accumulator and empties it. The accumulator is stored as two 32-bit words: the upper word holds bits 63:32 and the lower word holds bits 31:0.

Either word can be written directly through a special-register write port. A combinational read port returns one word at a time. Because every operation finishes in the clock that issues it, operations can be issued back to back with no wait states. This includes an empty-and-read straight after an accumulate.

Top module: `mac_unit`

## Requirements
- R1: Reset clears both accumulator words and the result output to zero.
- R2: With opCode 2'b01 (accumulate), the 64-bit accumulator becomes its old value plus the signed 64-bit product of opA and opB, one clock later.
- R3: With opCode 2'b10 (subtract), the accumulator becomes its old value minus the signed 64-bit product of opA and opB, one clock later.
- R4: With opCode 2'b11 (empty), clrResult takes accumulator bits 59:28, as they stood before the operation, and both words become zero, one clock later.
- R5: An operation can be issued on every clock. Each one acts on the value left by the operation before it.
- R6: sprWrLo or sprWrHi loads sprWrData into the lower or upper word one clock later. sprRdData shows the lower word when sprRdSel is 0 and the upper word when it is 1, in the same cycle.
- R7: When a word is written in the same clock as an operation, the written data wins for that word. The other word takes the operation's result.
- R8: With opCode 2'b00 and no write, both words and clrResult keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 2 | 00 idle, 01 accumulate, 10 subtract, 11 empty |
| opA | input | 32 | Signed operand A |
| opB | input | 32 | Signed operand B |
| sprWrLo | input | 1 | Write strobe for the lower word |
| sprWrHi | input | 1 | Write strobe for the upper word |
| sprWrData | input | 32 | Write data for the words |
| sprRdSel | input | 1 | Read select: 0 lower word, 1 upper word |
| sprRdData | output | 32 | Selected accumulator word |
| clrResult | output | 32 | Window returned by the last empty operation |

## Verification
A wrong carry or borrow between the two words, or a product built without signed extension, shows up in the upper word on the read port one clock after the operation. A wrong window slice, or a missing clear, shows up on clrResult, or on the read port, in the clock after an empty operation. The words are compared after every random step, so a corrupted word is caught within one clock. Write-versus-operation priority is driven on purpose in both directions, with each word written alone.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_ACC  = 2'b01,
    OP_SUB  = 2'b10,
    OP_CLR  = 2'b11
  } macOp_t;

  typedef struct packed {
    logic accEn;
    logic subSel;
    logic clrSel;
    logic wrLo;
    logic wrHi;
  } macStrobe_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic [1:0]  opCode,
  input  logic        sprWrLo,
  input  logic        sprWrHi,
  output macStrobe_t  strobe
);
  always_comb begin
    strobe        = '0;
    strobe.wrLo   = sprWrLo;
    strobe.wrHi   = sprWrHi;
    unique case (macOp_t'(opCode))
      OP_ACC:  strobe.accEn = 1'b1;
      OP_SUB:  begin strobe.accEn = 1'b1; strobe.subSel = 1'b1; end
      OP_CLR:  strobe.clrSel = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mac_dp.sv
module mac_dp
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SHIFT  = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  macStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] accLo,
  output logic [DATA_W-1:0] accHi,
  output logic [DATA_W-1:0] clrResult
);
  localparam int ACC_W = 2 * DATA_W;

  logic [ACC_W-1:0] accCur;
  logic [ACC_W-1:0] extA;
  logic [ACC_W-1:0] extB;
  logic [ACC_W-1:0] product;
  logic [ACC_W-1:0] accNext;
  logic [DATA_W-1:0] window;

  assign accCur  = {accHi, accLo};
  assign extA    = {{DATA_W{opA[DATA_W-1]}}, opA};
  assign extB    = {{DATA_W{opB[DATA_W-1]}}, opB};
  assign product = extA * extB;
  assign window  = accCur[SHIFT +: DATA_W];

  always_comb begin
    if (strobe.clrSel)      accNext = '0;
    else if (strobe.subSel) accNext = accCur - product;
    else                    accNext = accCur + product;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accLo     <= '0;
      accHi     <= '0;
      clrResult <= '0;
    end else begin
      if (strobe.wrLo)
        accLo <= wrData;
      else if (strobe.accEn || strobe.clrSel)
        accLo <= accNext[DATA_W-1:0];
      if (strobe.wrHi)
        accHi <= wrData;
      else if (strobe.accEn || strobe.clrSel)
        accHi <= accNext[ACC_W-1:DATA_W];
      if (strobe.clrSel)
        clrResult <= window;
    end
  end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SHIFT  = 28
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              sprWrLo,
  input  logic              sprWrHi,
  input  logic [DATA_W-1:0] sprWrData,
  input  logic              sprRdSel,
  output logic [DATA_W-1:0] sprRdData,
  output logic [DATA_W-1:0] clrResult
);
  macStrobe_t strobe;
  logic [DATA_W-1:0] accLo;
  logic [DATA_W-1:0] accHi;

  mac_ctrl u_ctrl (
    .opCode (opCode),
    .sprWrLo(sprWrLo),
    .sprWrHi(sprWrHi),
    .strobe (strobe)
  );

  mac_dp #(.DATA_W(DATA_W), .SHIFT(SHIFT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .wrData   (sprWrData),
    .accLo    (accLo),
    .accHi    (accHi),
    .clrResult(clrResult)
  );

  assign sprRdData = sprRdSel ? accHi : accLo;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              sprWrLo,
  input logic              sprWrHi,
  input logic [DATA_W-1:0] sprWrData,
  input logic [DATA_W-1:0] accLo,
  input logic [DATA_W-1:0] accHi,
  input logic [DATA_W-1:0] clrResult
);
  localparam int ACC_W = 2 * DATA_W;
  logic signed [ACC_W-1:0] prodRef;
  assign prodRef = $signed(opA) * $signed(opB);

  p_acc_add_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 2'b01 && !sprWrLo && !sprWrHi) |=>
      ({accHi, accLo} == $past({accHi, accLo}) + $past(prodRef)));

  p_acc_sub_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 2'b10 && !sprWrLo && !sprWrHi) |=>
      ({accHi, accLo} == $past({accHi, accLo}) - $past(prodRef)));

  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 2'b11 && !sprWrLo && !sprWrHi) |=> (accLo == '0 && accHi == '0));

  p_write_lo_r7: assert property (@(posedge clk) disable iff (!rstN)
    sprWrLo |=> (accLo == $past(sprWrData)));

  p_write_hi_r7: assert property (@(posedge clk) disable iff (!rstN)
    sprWrHi |=> (accHi == $past(sprWrData)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 2'b00 && !sprWrLo && !sprWrHi) |=>
      ($stable(accLo) && $stable(accHi) && $stable(clrResult)));
endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opCode   (opCode),
  .opA      (opA),
  .opB      (opB),
  .sprWrLo  (sprWrLo),
  .sprWrHi  (sprWrHi),
  .sprWrData(sprWrData),
  .accLo    (accLo),
  .accHi    (accHi),
  .clrResult(clrResult)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opCode = 2'b00;
  logic [31:0] opA = '0, opB = '0, sprWrData = '0;
  logic        sprWrLo = 1'b0, sprWrHi = 1'b0, sprRdSel = 1'b0;
  logic [31:0] sprRdData, clrResult;

  int checks = 0;
  int errors = 0;
  logic [63:0] expAcc = '0;
  logic [31:0] expRes = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit u0 (
    .clk(clk), .rstN(rstN), .opCode(opCode), .opA(opA), .opB(opB),
    .sprWrLo(sprWrLo), .sprWrHi(sprWrHi), .sprWrData(sprWrData),
    .sprRdSel(sprRdSel), .sprRdData(sprRdData), .clrResult(clrResult)
  );

  function automatic logic [63:0] sprod(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] x, y;
    x = {{32{a[31]}}, a};
    y = {{32{b[31]}}, b};
    return x * y;
  endfunction

  function automatic logic [63:0] modelNext(input logic [63:0] acc, input logic [1:0] op,
                                            input logic [31:0] a, input logic [31:0] b);
    case (op)
      2'b01:   return acc + sprod(a, b);
      2'b10:   return acc - sprod(a, b);
      2'b11:   return 64'd0;
      default: return acc;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag);
    sprRdSel = 1'b0; #1;
    cmp({tag, " lo"}, sprRdData, expAcc[31:0]);
    sprRdSel = 1'b1; #1;
    cmp({tag, " hi"}, sprRdData, expAcc[63:32]);
    cmp({tag, " res"}, clrResult, expRes);
  endtask

  // Drive at negedge, clock once, update model, return at next negedge.
  task automatic step(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic wl, input logic wh, input logic [31:0] wd);
    logic [63:0] nxt;
    opCode = op; opA = a; opB = b; sprWrLo = wl; sprWrHi = wh; sprWrData = wd;
    nxt = modelNext(expAcc, op, a, b);
    if (op == 2'b11) expRes = expAcc[59:28];
    if (wl) nxt[31:0] = wd;
    if (wh) nxt[63:32] = wd;
    @(posedge clk);
    expAcc = nxt;
    @(negedge clk);
    opCode = 2'b00; sprWrLo = 1'b0; sprWrHi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkState("R1 reset");

    step(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
    checkState("R2 acc -1*-1");
    step(2'b01, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);
    checkState("R2 acc min*min");
    step(2'b10, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 0);
    checkState("R3 sub max*min");
    step(2'b10, 32'h0001_0000, 32'h0001_0000, 0, 0, 0);
    checkState("R3 sub borrow");
    step(2'b00, 32'h1234, 32'h5678, 0, 0, 0);
    checkState("R8 idle hold");
    step(2'b11, 0, 0, 0, 0, 0);
    checkState("R4 clear");

    step(2'b10, 32'h0000_0003, 32'h1000_0000, 0, 0, 0);
    step(2'b11, 0, 0, 0, 0, 0);
    checkState("R4 clear negative");

    step(2'b00, 0, 0, 1, 0, 32'hDEAD_BEEF);
    checkState("R6 write lo");
    step(2'b00, 0, 0, 0, 1, 32'h8765_4321);
    checkState("R6 write hi");

    step(2'b01, 32'h0000_0010, 32'h0000_0020, 1, 0, 32'h1111_1111);
    checkState("R7 write lo over acc");
    step(2'b11, 0, 0, 0, 1, 32'h2222_2222);
    checkState("R7 write hi over clear");

    step(2'b01, 32'h0F00_0000, 32'h0000_0100, 0, 0, 0);
    step(2'b11, 0, 0, 0, 0, 0);
    checkState("R5 clear right after acc");

    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      logic wl, wh;
      op = 2'($urandom());
      wl = ($urandom() % 8) == 0;
      wh = ($urandom() % 8) == 0;
      step(op, $urandom(), $urandom(), wl, wh, $urandom());
      checkState("R5 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule